// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a small synchronous up-counter, four bits wide by default. Every change of state happens on the rising clock edge. A clear input forces the count to zero. A load input copies a parallel data word into the count. The count advances by one only when two separate enables are both high. One of those enables, the carry-in, also qualifies the terminal-count output. This lets several stages be chained: each stage's terminal count drives the next stage's carry-in, and every stage shares one clock.

Clear and load are synchronous, so a counter of arbitrary modulus can be built without glitches on the outputs. A `MODULUS` parameter selects this variant. When `MODULUS` is below the full binary range, an internal decode of the last state folds a clear into the next counting edge. The count then runs 0 to `MODULUS-1` and wraps. The default `MODULUS` of `2**WIDTH` gives a plain binary count.

Top module: `sync_bin_counter`

## Requirements
- R1: While `clrN` is low, the next rising edge sets `q` to 0, whatever `loadN`, `cntEn`, `carryIn` and `dIn` are. `q` does not change between edges.
- R2: While `clrN` is high and `loadN` is low, the next rising edge copies `dIn` into `q`, whatever the two enables are.
- R3: While `clrN` and `loadN` are high and `cntEn` and `carryIn` are both high, each rising edge adds one to `q` modulo 2**WIDTH, so 15 is followed by 0.
- R4: While `clrN` and `loadN` are high and either `cntEn` or `carryIn` is low, `q` holds its value across the edge.
- R5: `termCnt` is 1 exactly when `q` is all ones (1111) and `carryIn` is 1. It ignores `cntEn` and follows `q` and `carryIn` in the same cycle, with no register in between.
- R6: When the `termCnt` of one stage drives the `carryIn` of a second stage, with both `cntEn` high, the pair counts as one 8-bit binary counter. The upper stage advances once every 16 counts of the lower stage.
- R7: When `MODULUS` is below 2**WIDTH, a counting edge taken at `q == MODULUS-1` returns `q` to 0. With counting inhibited, that state holds. Moduli 5 and 11 give the sequences 0..4 and 0..10.
- R8: The sequence clear, load 12, six counts, then inhibit gives `q` = 0, 12, 13, 14, 15, 0, 1, 2, followed by 2 held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Synchronous clear, active low, highest priority |
| loadN | input | 1 | Synchronous parallel load, active low |
| dIn | input | WIDTH | Parallel data loaded when `loadN` is low |
| cntEn | input | 1 | Count enable that does not affect `termCnt` |
| carryIn | input | 1 | Count enable that also qualifies `termCnt` |
| q | output | WIDTH | Counter state |
| termCnt | output | 1 | Terminal count, all ones qualified by `carryIn` |

## Verification
The directed sequence combines load, roll-over and inhibit. It shows that loading a value near the top leads into a correct wrap through zero. Priority patterns assert clear and load together, and load with both enables low. These separate the clear-over-load-over-count order from a design that lets the enables gate the synchronous controls. Patterns that lower each enable alone, with `q` parked at 1111, tell the two enables apart: only `carryIn` may drop `termCnt`. A two-stage chain runs past 255, and two modulus variants run in parallel, including a hold on the last state. These show that the carry and the early wrap land on the right edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  // Per-edge action chosen by the control; at most one is set.
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doCount;
  } ctrlStrobes_t;

endpackage

// File: rtl/counter_ctrl.sv
module counter_ctrl
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned MODULUS = 2 ** WIDTH
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             loadN,
  input  logic             cntEn,
  input  logic             carryIn,
  input  logic [WIDTH-1:0] qNow,
  output ctrlStrobes_t     strobes,
  output logic             termCnt
);

  localparam int unsigned     FULL_RANGE = 2 ** WIDTH;
  localparam bit              WRAP_EARLY = (MODULUS < FULL_RANGE);
  localparam logic [WIDTH-1:0] LAST_VAL  = WIDTH'(MODULUS - 1);

  logic countGo;
  logic wrapHit;

  assign countGo = clrN & loadN & cntEn & carryIn;

  generate
    if (WRAP_EARLY) begin : g_modWrap
      assign wrapHit = (qNow == LAST_VAL);
    end else begin : g_binWrap
      assign wrapHit = 1'b0;
    end
  endgenerate

  always_comb begin
    strobes.doClear = ~clrN | (countGo & wrapHit);
    strobes.doLoad  = clrN & ~loadN;
    strobes.doCount = countGo & ~wrapHit;
  end

  // Look-ahead carry: no register, so a following stage sees it this cycle.
  assign termCnt = (&qNow) & carryIn;

  // R1 R2 R3: priority leaves a single action per edge
  strobe_onehot_chk: assert property (@(posedge clk) $onehot0(strobes));

  // R5
  tc_needs_carry_chk: assert property (@(posedge clk) !carryIn |-> !termCnt);

  generate
    if (WRAP_EARLY) begin : g_wrapChk
      // R7
      mod_wrap_chk: assert property (@(posedge clk)
        (countGo && qNow == LAST_VAL) |-> (strobes.doClear && !strobes.doCount));
    end
  endgenerate

endmodule

// File: rtl/counter_datapath.sv
module counter_datapath
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] countReg;

  always_ff @(posedge clk) begin
    if (strobes.doClear)      countReg <= '0;
    else if (strobes.doLoad)  countReg <= dIn;
    else if (strobes.doCount) countReg <= countReg + ONE;
  end

  assign q = countReg;

  // R1
  clear_to_zero_chk: assert property (@(posedge clk)
    strobes.doClear |=> (q == '0));

  // R2
  load_value_chk: assert property (@(posedge clk)
    strobes.doLoad |=> (q == $past(dIn)));

  // R3
  count_step_chk: assert property (@(posedge clk)
    strobes.doCount |=> (q == WIDTH'($past(q) + ONE)));

  // R4
  hold_value_chk: assert property (@(posedge clk)
    !(strobes.doClear || strobes.doLoad || strobes.doCount) |=> $stable(q));

endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned MODULUS = 2 ** WIDTH
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dIn,
  input  logic             cntEn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] q,
  output logic             termCnt
);

  ctrlStrobes_t strobes;

  counter_ctrl #(
    .WIDTH  (WIDTH),
    .MODULUS(MODULUS)
  ) ctrl_i (
    .clk    (clk),
    .clrN   (clrN),
    .loadN  (loadN),
    .cntEn  (cntEn),
    .carryIn(carryIn),
    .qNow   (q),
    .strobes(strobes),
    .termCnt(termCnt)
  );

  counter_datapath #(
    .WIDTH(WIDTH)
  ) data_i (
    .clk    (clk),
    .strobes(strobes),
    .dIn    (dIn),
    .q      (q)
  );

endmodule

// File: tb/sync_bin_counter_tb_top.sv
module sync_bin_counter_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  // Main device: driven by the scoreboard driver
  logic       clrN = 1'b1, loadN = 1'b1, cntEn = 1'b0, carryIn = 1'b0;
  logic [3:0] dIn = 4'd0;
  logic [3:0] q;
  logic       termCnt;

  sync_bin_counter dut_i (
    .clk(clk), .clrN(clrN), .loadN(loadN), .dIn(dIn),
    .cntEn(cntEn), .carryIn(carryIn), .q(q), .termCnt(termCnt)
  );

  // Cascade and modulus devices share these controls
  logic       cClr = 1'b1, cEn = 1'b0;
  logic [3:0] loQ, hiQ, m5Q, m11Q;
  logic       loTc, hiTc, m5Tc, m11Tc;

  sync_bin_counter loStage (
    .clk(clk), .clrN(cClr), .loadN(1'b1), .dIn(4'd0),
    .cntEn(1'b1), .carryIn(cEn), .q(loQ), .termCnt(loTc)
  );
  sync_bin_counter hiStage (
    .clk(clk), .clrN(cClr), .loadN(1'b1), .dIn(4'd0),
    .cntEn(1'b1), .carryIn(loTc), .q(hiQ), .termCnt(hiTc)
  );
  sync_bin_counter #(.WIDTH(4), .MODULUS(5)) mod5 (
    .clk(clk), .clrN(cClr), .loadN(1'b1), .dIn(4'd0),
    .cntEn(1'b1), .carryIn(cEn), .q(m5Q), .termCnt(m5Tc)
  );
  sync_bin_counter #(.WIDTH(4), .MODULUS(11)) mod11 (
    .clk(clk), .clrN(cClr), .loadN(1'b1), .dIn(4'd0),
    .cntEn(1'b1), .carryIn(cEn), .q(m11Q), .termCnt(m11Tc)
  );

  int compared = 0;
  int mismatched = 0;
  bit runDone = 1'b0;

  task automatic checkVal(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct {
    logic [3:0] expQ;
    logic       expTc;
    string      tag;
  } sbItem_t;

  sbItem_t    sbQ[$];
  logic [3:0] modelQ = 4'd0;

  // Driver: set inputs at the falling edge and queue the result due after the next rising edge
  task automatic step(input logic c, input logic l, input logic [3:0] d,
                      input logic ce, input logic ci, input string tag);
    logic [3:0] nxt;
    sbItem_t    it;
    @(negedge clk);
    clrN = c; loadN = l; dIn = d; cntEn = ce; carryIn = ci;
    if (!c)            nxt = 4'd0;
    else if (!l)       nxt = d;
    else if (ce && ci) nxt = modelQ + 4'd1;
    else               nxt = modelQ;
    modelQ   = nxt;
    it.expQ  = nxt;
    it.expTc = (nxt == 4'hF) && ci;
    it.tag   = tag;
    sbQ.push_back(it);
  endtask

  // Monitor: compare just after each rising edge
  initial begin : monitor
    sbItem_t got;
    forever begin
      @(posedge clk);
      #3;
      if (sbQ.size() > 0) begin
        got = sbQ.pop_front();
        checkVal({got.tag, " q"}, int'(q), int'(got.expQ));
        checkVal({got.tag, " termCnt"}, int'(termCnt), int'(got.expTc));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!runDone) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stimulus
    int total;

    // R8 directed sequence (R1 reset state, R2 preset, R3 roll-over, R4 inhibit)
    step(1'b0, 1'b1, 4'd0,  1'b1, 1'b1, "R8/R1 clear to 0");
    step(1'b1, 1'b0, 4'd12, 1'b1, 1'b1, "R8/R2 preset 12");
    step(1'b1, 1'b1, 4'd0,  1'b1, 1'b1, "R8 count 13");
    step(1'b1, 1'b1, 4'd0,  1'b1, 1'b1, "R8 count 14");
    step(1'b1, 1'b1, 4'd0,  1'b1, 1'b1, "R8/R5 count 15");
    step(1'b1, 1'b1, 4'd0,  1'b1, 1'b1, "R8/R3 wrap 0");
    step(1'b1, 1'b1, 4'd0,  1'b1, 1'b1, "R8 count 1");
    step(1'b1, 1'b1, 4'd0,  1'b1, 1'b1, "R8 count 2");
    step(1'b1, 1'b1, 4'd0,  1'b0, 1'b1, "R8/R4 inhibit hold 2");
    step(1'b1, 1'b1, 4'd0,  1'b0, 1'b0, "R8/R4 inhibit hold 2 again");

    // R4: each enable alone low holds
    step(1'b1, 1'b1, 4'd9,  1'b1, 1'b0, "R4 carryIn low holds");
    step(1'b1, 1'b1, 4'd9,  1'b0, 1'b1, "R4 cntEn low holds");

    // R1: clear beats load and enables
    step(1'b1, 1'b0, 4'd7,  1'b0, 1'b0, "R2 load with enables low");
    step(1'b0, 1'b0, 4'd5,  1'b1, 1'b1, "R1 clear beats load");
    step(1'b1, 1'b0, 4'd10, 1'b1, 1'b1, "R2 load beats count");

    // R5: terminal count ignores cntEn, follows carryIn
    step(1'b1, 1'b0, 4'd15, 1'b0, 1'b1, "R5 tc with cntEn low");
    step(1'b1, 1'b1, 4'd0,  1'b0, 1'b0, "R5 tc dropped by carryIn");
    step(1'b1, 1'b1, 4'd0,  1'b0, 1'b1, "R5 tc restored");
    step(1'b1, 1'b1, 4'd0,  1'b1, 1'b1, "R3 wrap 15 to 0");
    step(1'b1, 1'b0, 4'd14, 1'b1, 1'b1, "R5 load 14 no tc");

    repeat (3) @(posedge clk);

    // R6 cascade, R7 modulus variants
    @(negedge clk);
    cClr = 1'b0; cEn = 1'b0;
    @(posedge clk); #3;
    checkVal("R1 cascade clear", int'({hiQ, loQ}), 0);
    checkVal("R7 mod5 clear", int'(m5Q), 0);
    checkVal("R7 mod11 clear", int'(m11Q), 0);

    total = 0;
    for (int i = 0; i < 310; i++) begin
      @(negedge clk);
      cClr = 1'b1;
      cEn  = !(i >= 304 && i < 307);
      @(posedge clk); #3;
      if (cEn) total++;
      checkVal("R6 cascade value", int'({hiQ, loQ}), total % 256);
      checkVal("R6 upper stage tc", int'(hiTc), ((total % 256) == 255 && cEn) ? 1 : 0);
      checkVal("R7 mod5 value", int'(m5Q), total % 5);
      checkVal("R7 mod11 value", int'(m11Q), total % 11);
    end

    runDone = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule